// File: doc/BRIEF.md
# Interruptible Block Move Engine

This block copies a run of bytes or 16-bit words from one memory region to another. A caller starts it with three register values: the source address, the destination address and an element count. It also says whether the run is made of bytes or of words. The engine then reads one element from the source and writes it to the destination. After each element it advances both pointers and lowers the count. Its current pointer and count values are always visible on its outputs, so the caller can copy them back into its register file at any moment.

Memory is reached through one request channel with a valid/ready handshake, plus a separate read-response strobe. Only one access is outstanding at a time. An interrupt request is sampled only at element boundaries. When it stops the run, the registers describe exactly the part that is left. Starting the engine again with those values finishes the copy. A stored count of zero stands for 65536 elements.

Top module: `blk_move_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `suspended`, `align_err` and `mem_req_valid` are all 0.
- R2: Each element is one read of the source pointer followed by one write to the destination pointer. No request is raised while a read response is still owed. A raised request keeps its address until `mem_req_ready` is seen.
- R3: In byte mode (`word_mode`=0), `mem_req_byte` is 1. Only bits 7:0 of the read data are moved, and the write data carries them in bits 7:0. Both pointers step by 1 per element.
- R4: In word mode (`word_mode`=1), `mem_req_byte` is 0. All 16 data bits are moved, and both pointers step by 2 per element.
- R5: The count output drops by 1 as each write is accepted. When it goes from 1 to 0, the run ends with `done`=1 and the pointers one element past the last one moved.
- R6: A start count of 0 is treated as 65536 elements. The first element is moved and the count becomes 16'hFFFF, rather than the run ending at once.
- R7: If `irq` is 1 when an element's write is accepted and the count has not reached 0, the engine stops with `suspended`=1. The registers then hold the remaining work. Restarting with those values completes the copy.
- R8: A word-mode start with an odd source or destination address sets `align_err`, loads no register and issues no memory request.
- R9: `irq` has no effect on the final element: that element ends the run with `done`=1 and `suspended`=0.
- R10: `start` is ignored while `busy` is 1. The `done`, `suspended` and `align_err` flags stay set until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (taken only when idle) |
| word_mode | input | 1 | 1 = 16-bit words, 0 = bytes |
| src_in | input | AW | Initial source address |
| dst_in | input | AW | Initial destination address |
| cnt_in | input | CW | Initial element count (0 means 65536) |
| irq | input | 1 | Interrupt request, sampled at element boundaries |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_byte | output | 1 | 1 = byte access, 0 = word access |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 16 | Read data |
| busy | output | 1 | Move in progress |
| done | output | 1 | Run completed |
| suspended | output | 1 | Run paused by interrupt |
| align_err | output | 1 | Word move refused for odd address |
| src_reg | output | AW | Current source pointer |
| dst_reg | output | AW | Current destination pointer |
| cnt_reg | output | CW | Current remaining count |

## Verification
The bench checks the count of zero. A design that treated it as empty would finish at once and copy nothing. The bench checks an interrupt that is held high through the last element. A design that tested the interrupt before the end-of-count test would report a suspension with a count of zero.

It suspends a word move after its first element and restarts it from the exposed registers. A design that committed pointers late, or stepped them by 1 in word mode, would skip or repeat data. It also sends odd addresses in word mode, where a faulty design would touch memory. Finally, it pulses start during a run, where a faulty design would reload its registers partway through. A memory model with irregular ready and late responses is used to expose handshake faults.

// File: rtl/blk_move_engine.sv
module blk_move_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          word_mode,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic          irq,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic          mem_req_byte,
  output logic [AW-1:0] mem_req_addr,
  output logic [15:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [15:0]   mem_rsp_rdata,
  output logic          busy,
  output logic          done,
  output logic          suspended,
  output logic          align_err,
  output logic [AW-1:0] src_reg,
  output logic [AW-1:0] dst_reg,
  output logic [CW-1:0] cnt_reg
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} state_t;
  state_t          state;
  logic            wmode;
  logic [15:0]     data;
  logic [AW-1:0]   step;
  logic            last;

  assign step          = wmode ? AW'(2) : AW'(1);
  assign last          = (cnt_reg == CW'(1));
  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_RD) || (state == S_WR);
  assign mem_req_write = (state == S_WR);
  assign mem_req_byte  = ~wmode;
  assign mem_req_addr  = (state == S_WR) ? dst_reg : src_reg;
  assign mem_req_wdata = wmode ? data : {8'h00, data[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wmode     <= 1'b0;
      data      <= '0;
      src_reg   <= '0;
      dst_reg   <= '0;
      cnt_reg   <= '0;
      done      <= 1'b0;
      suspended <= 1'b0;
      align_err <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done      <= 1'b0;
          suspended <= 1'b0;
          align_err <= 1'b0;
          if (word_mode && (src_in[0] || dst_in[0])) begin
            align_err <= 1'b1;
          end else begin
            wmode   <= word_mode;
            src_reg <= src_in;
            dst_reg <= dst_in;
            cnt_reg <= cnt_in;
            state   <= S_RD;
          end
        end
        S_RD:    if (mem_req_ready) state <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          data  <= mem_rsp_rdata;
          state <= S_WR;
        end
        S_WR: if (mem_req_ready) begin
          src_reg <= src_reg + step;
          dst_reg <= dst_reg + step;
          cnt_reg <= cnt_reg - CW'(1);
          if (last) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (irq) begin
            suspended <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_move_engine_chk.sv
module blk_move_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic          mem_req_byte,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          done,
  input logic          suspended,
  input logic          align_err,
  input logic [CW-1:0] cnt_reg
);
  logic rd_owed;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_owed <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_owed <= 1'b1;
    else if (mem_rsp_valid) rd_owed <= 1'b0;
  end

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_owed |-> !mem_req_valid);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_byte) |-> !mem_req_addr[0]);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> (cnt_reg == $past(cnt_reg) - CW'(1)));

  // R8
  align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !mem_req_valid);

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && suspended));
endmodule

bind blk_move_engine blk_move_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_byte(mem_req_byte), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .done(done), .suspended(suspended),
  .align_err(align_err), .cnt_reg(cnt_reg)
);

// File: tb/blk_move_engine_tb.sv
module blk_move_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, word_mode = 1'b0, irq = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic mem_req_valid, mem_req_write, mem_req_byte;
  logic mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_rdata = '0;
  logic busy, done, suspended, align_err;
  logic [15:0] src_reg, dst_reg, cnt_reg;

  int total = 0, fails = 0, cyc = 0, writes = 0, proto_bad = 0;
  logic [7:0] mem [0:4095];
  logic [15:0] lfsr = 16'hACE1;
  logic rd_pend = 1'b0, rd_byte = 1'b0;
  logic [15:0] rd_addr = '0;

  always #2 clk = ~clk;

  blk_move_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .irq(irq),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_byte(mem_req_byte),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .busy(busy), .done(done), .suspended(suspended), .align_err(align_err),
    .src_reg(src_reg), .dst_reg(dst_reg), .cnt_reg(cnt_reg)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Memory model: irregular ready, read data one cycle after acceptance
  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    mem_rsp_valid <= 1'b0;
    if (rd_pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= rd_byte ? {8'h00, mem[rd_addr[11:0]]}
                               : {mem[rd_addr[11:0] + 12'd1], mem[rd_addr[11:0]]};
      rd_pend <= 1'b0;
    end
    if (mem_req_valid && rd_pend) proto_bad++;
    if (mem_req_valid && mem_req_ready && rst_n) begin
      if (mem_req_write) begin
        writes++;
        mem[mem_req_addr[11:0]] = mem_req_wdata[7:0];
        if (!mem_req_byte) mem[mem_req_addr[11:0] + 12'd1] = mem_req_wdata[15:8];
      end else begin
        rd_pend <= 1'b1;
        rd_addr <= mem_req_addr;
        rd_byte <= mem_req_byte;
      end
    end
    if (cyc == 150000) begin
      chk(1'b0, "WD", "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic fill(input int base, input int n, input int seed);
    for (int i = 0; i < n; i++) mem[(base + i) & 12'hFFF] = 8'((i * 37 + seed) ^ 8'h5A);
  endtask

  task automatic launch(input bit w, input int s, input int d, input int c);
    @(negedge clk);
    word_mode = w; src_in = 16'(s); dst_in = 16'(d); cnt_in = 16'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int t = 0; t < 20000; t++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !suspended && !align_err && !mem_req_valid,
        "R1", "idle after reset", {busy, done, suspended, align_err, mem_req_valid}, 0);
  endtask

  task automatic t_byte_copy();
    int bad = 0;
    fill(16'h100, 5, 3);
    for (int i = 0; i < 6; i++) mem[16'h301 + i] = 8'hEE;
    writes = 0;
    launch(1'b0, 16'h100, 16'h301, 5);
    wait_end();
    chk(done && !suspended, "R5", "byte run done", done, 1);
    chk(src_reg == 16'h105 && dst_reg == 16'h306, "R3", "byte pointers step 1",
        dst_reg, 16'h306);
    chk(cnt_reg == 0, "R5", "byte count ends 0", cnt_reg, 0);
    for (int i = 0; i < 5; i++) if (mem[16'h301 + i] != mem[16'h100 + i]) bad++;
    chk(bad == 0, "R3", "byte data copied", bad, 0);
    chk(mem[16'h306] == 8'hEE, "R3", "byte past end untouched", mem[16'h306], 8'hEE);
    chk(writes == 5, "R2", "one write per byte", writes, 5);
  endtask

  task automatic t_word_copy();
    int bad = 0;
    fill(16'h200, 8, 11);
    for (int i = 0; i < 10; i++) mem[16'h400 + i] = 8'h00;
    launch(1'b1, 16'h200, 16'h400, 4);
    wait_end();
    chk(done, "R4", "word run done", done, 1);
    chk(src_reg == 16'h208 && dst_reg == 16'h408, "R4", "word pointers step 2",
        src_reg, 16'h208);
    for (int i = 0; i < 8; i++) if (mem[16'h400 + i] != mem[16'h200 + i]) bad++;
    chk(bad == 0, "R4", "word data, both bytes", bad, 0);
    chk(mem[16'h408] == 8'h00, "R4", "word past end untouched", mem[16'h408], 0);
  endtask

  task automatic t_irq_suspend();
    int bad = 0;
    fill(16'h500, 12, 29);
    for (int i = 0; i < 12; i++) mem[16'h600 + i] = 8'h00;
    irq = 1'b1;
    launch(1'b1, 16'h500, 16'h600, 6);
    wait_end();
    chk(suspended && !done, "R7", "suspended by irq", suspended, 1);
    chk(cnt_reg == 5 && src_reg == 16'h502 && dst_reg == 16'h602, "R7",
        "registers after one element", cnt_reg, 5);
    chk(mem[16'h602] == 8'h00, "R7", "second element not yet moved", mem[16'h602], 0);
    irq = 1'b0;
    launch(1'b1, src_reg, dst_reg, cnt_reg);
    wait_end();
    chk(done && !suspended, "R7", "resumed run done", done, 1);
    for (int i = 0; i < 12; i++) if (mem[16'h600 + i] != mem[16'h500 + i]) bad++;
    chk(bad == 0, "R7", "resumed copy complete", bad, 0);
  endtask

  task automatic t_irq_last();
    irq = 1'b1;
    launch(1'b0, 16'h700, 16'h710, 1);
    wait_end();
    irq = 1'b0;
    chk(done && !suspended, "R9", "irq on last element ignored", suspended, 0);
    chk(cnt_reg == 0 && mem[16'h710] == mem[16'h700], "R9", "last element moved",
        cnt_reg, 0);
  endtask

  task automatic t_zero_count();
    mem[16'h800] = 8'hA5; mem[16'h900] = 8'h00;
    irq = 1'b1;
    launch(1'b0, 16'h800, 16'h900, 0);
    wait_end();
    irq = 1'b0;
    chk(suspended && !done, "R6", "zero count does not finish", done, 0);
    chk(cnt_reg == 16'hFFFF && src_reg == 16'h801, "R6", "zero count wraps",
        cnt_reg, 16'hFFFF);
    chk(mem[16'h900] == 8'hA5, "R6", "first element moved", mem[16'h900], 8'hA5);
  endtask

  task automatic t_align();
    mem[16'hA00] = 8'h00; mem[16'hA01] = 8'h00;
    writes = 0;
    launch(1'b1, 16'hB01, 16'hA00, 2);
    repeat (4) @(negedge clk);
    chk(align_err && !busy, "R8", "odd source refused", align_err, 1);
    chk(writes == 0 && src_reg != 16'hB01, "R8", "nothing loaded or written", writes, 0);
    launch(1'b1, 16'hB00, 16'hA01, 2);
    repeat (4) @(negedge clk);
    chk(align_err && writes == 0, "R8", "odd destination refused", writes, 0);
    chk(align_err, "R10", "align flag held", align_err, 1);
    launch(1'b0, 16'hB00, 16'hA00, 1);
    chk(!align_err, "R10", "new start clears flag", align_err, 0);
    wait_end();
  endtask

  task automatic t_busy_start();
    int bad = 0;
    fill(16'hC00, 4, 71);
    for (int i = 0; i < 4; i++) mem[16'hD00 + i] = 8'h00;
    mem[16'hE00] = 8'h77;
    launch(1'b0, 16'hC00, 16'hD00, 4);
    launch(1'b0, 16'hE00, 16'hE80, 1);
    wait_end();
    chk(done && src_reg == 16'hC04 && dst_reg == 16'hD04, "R10",
        "start while busy ignored", dst_reg, 16'hD04);
    for (int i = 0; i < 4; i++) if (mem[16'hD00 + i] != mem[16'hC00 + i]) bad++;
    chk(bad == 0 && mem[16'hE80] != 8'h77, "R10", "original copy intact", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_copy();
    t_word_copy();
    t_irq_suspend();
    t_irq_last();
    t_zero_count();
    t_align();
    t_busy_start();
    chk(proto_bad == 0, "R2", "no request while read owed", proto_bad, 0);
    summary();
    $finish;
  end
endmodule